// File: doc/BRIEF.md
# Multicast Spike Packet Router

This block steers spike events between six neighbouring-chip links and a group of local processor ports. Each arriving packet carries an 8-bit header, a 32-bit routing key and, when the header says so, a 32-bit payload word. The key is tested against a table of key/mask entries. The lowest-numbered entry that matches supplies a destination vector, and the packet is offered to every output named in that vector at the same time.

Packets that no entry claims are handled by where they came from. A packet that arrived on a link carries straight on through the opposite link. A packet from a local core is discarded. If a selected link is marked failed when the packet is dispatched, or still refuses the packet after a programmable wait, that copy is sent on a neighbouring link direction and tagged so that the next chip can turn it back onto the intended heading. If any copy is still waiting when the programmable time limit expires, the rest of the packet is abandoned. A saturating counter records every packet that is discarded.

The router handles one packet at a time. Integration needs only a host write port to fill the table, two configuration words and the per-link failure flags.

Top module: `spike_router`

## Requirements
- R1: Header bit 0 set means a payload word is present, and `out_payload` then equals the input payload. When bit 0 is clear, `out_payload` is zero. The key and header bits 7:3 and 0 are forwarded unchanged.
- R2: Table entry i matches when its enable bit, written through `tbl_en`, is set and `(key & mask_i) == key_i`. Writing with `tbl_we` at `tbl_addr` replaces key, mask, destination and enable. A disabled entry never matches.
- R3: When several enabled entries match, the lowest address supplies the destination vector.
- R4: Destination bit k selects link k for k = 0..5 and local core k-6 for k ≥ 6. All selected outputs assert `out_valid` together. Each bit stays set until its `out_ready` is seen. `in_ready` stays low until every copy is accepted or the packet is dropped.
- R5: Lookup latency is fixed. When a packet is accepted at rising edge N, `out_valid` is first set after rising edge N+2.
- R6: A packet from link a (`in_src` = a) that matches no entry is sent only on link (a+3) mod 6.
- R7: A packet from a core (`in_src` ≥ 6) that matches no entry produces no output, and `drop_count` rises by one.
- R8: Outputs are offered for at most `cfg_timeout` cycles. If any copy is still pending at the end of that window, the packet is abandoned, `out_valid` clears and `drop_count` rises by one.
- R9: A link selected at dispatch whose `link_failed` bit is set is replaced by link (d+1) mod 6 with header bits 2:1 = 01, provided that link is neither selected nor failed. Otherwise it is replaced by link (d+5) mod 6 with header bits 2:1 = 10.
- R10: A link copy still pending after `cfg_detour_wait`+1 offered cycles is moved to another link by the rule of R9. The detour link must not already have been used for this packet.
- R11: A packet arriving on link a with header bits 2:1 = 01 bypasses the table and leaves only on link (a+1) mod 6. With bits 2:1 = 10 it leaves only on link (a+5) mod 6. In both cases the outgoing bits 2:1 are 00.
- R12: `drop_count` saturates at its all-ones value.
- R13: After reset, `in_ready` is 1, `out_valid` is 0 and `drop_count` is 0. All table entries are disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input packet offered |
| in_ready | output | 1 | Router idle and able to take a packet |
| in_src | input | SRC_W | Arrival port: 0..5 link, 6.. core |
| in_hdr | input | 8 | Header: bit 0 payload present, bits 2:1 detour code |
| in_key | input | 32 | Routing key |
| in_payload | input | 32 | Payload word |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | AW | Table entry address |
| tbl_en | input | 1 | Entry enable written with the entry |
| tbl_key | input | 32 | Entry key |
| tbl_mask | input | 32 | Entry mask |
| tbl_dest | input | NUM_OUT | Entry destination vector |
| cfg_timeout | input | TMO_W | Offer window in cycles (≥ 1) |
| cfg_detour_wait | input | TMO_W | Offered cycles minus one before a blocked link is detoured |
| link_failed | input | 6 | Per-link failure flags |
| out_valid | output | NUM_OUT | Per-output copy offered |
| out_ready | input | NUM_OUT | Per-output acceptance |
| out_hdr | output | NUM_OUT*8 | Per-output header, output k at bits 8k+7:8k |
| out_key | output | 32 | Key shared by all outputs |
| out_payload | output | 32 | Payload shared by all outputs |
| drop_count | output | DROP_W | Saturating count of discarded packets |

## Verification
The assertions assume that `cfg_timeout` is at least one and that both configuration words hold still while a packet is in flight. They also assume that `in_src` names an existing port and that table addresses stay below the table depth. `out_ready` may change in any cycle. The stimulus changes configuration, failure flags and table contents only while `in_ready` is high. It offers a packet only when the router is idle, and drives every index within the configured port and entry counts.

// File: rtl/spike_router_pkg.sv
package spike_router_pkg;
   localparam int NUM_LINKS = 6;
   localparam int KEY_W     = 32;
   localparam int HDR_W     = 8;
   localparam int PL_BIT    = 0;
   localparam int ER_LO     = 1;

   typedef enum logic [1:0] {
      ER_NONE = 2'b00,
      ER_CW   = 2'b01,
      ER_CCW  = 2'b10,
      ER_RSV  = 2'b11
   } er_code_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_LOOK,
      ST_DISP,
      ST_SEND
   } state_e;

   // rotate a link direction by k steps around the hexagon
   function automatic logic [2:0] link_add(input logic [2:0] l, input int unsigned k);
      return 3'((32'(l) + k) % NUM_LINKS);
   endfunction
endpackage

// File: rtl/srt_table.sv
module srt_table
   import spike_router_pkg::*;
#(
   parameter int DEPTH   = 16,
   parameter int NUM_OUT = 10,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [AW-1:0]      wr_addr,
   input  logic               wr_valid,
   input  logic [KEY_W-1:0]   wr_key,
   input  logic [KEY_W-1:0]   wr_mask,
   input  logic [NUM_OUT-1:0] wr_dest,
   input  logic               lk_en,
   input  logic [KEY_W-1:0]   lk_key,
   output logic               hit_q,
   output logic [NUM_OUT-1:0] dest_q
);
   logic [DEPTH-1:0]   ent_v;
   logic [KEY_W-1:0]   ent_key  [DEPTH];
   logic [KEY_W-1:0]   ent_mask [DEPTH];
   logic [NUM_OUT-1:0] ent_dest [DEPTH];
   logic [DEPTH-1:0]   match;
   logic [NUM_OUT-1:0] sel_dest;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ent_v <= '0;
      else if (wr_en) ent_v[wr_addr] <= wr_valid;
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         ent_key[wr_addr]  <= wr_key;
         ent_mask[wr_addr] <= wr_mask;
         ent_dest[wr_addr] <= wr_dest;
      end
   end

   // one ternary comparator per entry
   for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      assign match[g] = ent_v[g] && ((lk_key & ent_mask[g]) == ent_key[g]);
   end

   // lowest index wins: scan from the top so the last write is the smallest hit
   always_comb begin
      sel_dest = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (match[i]) sel_dest = ent_dest[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_q  <= 1'b0;
         dest_q <= '0;
      end else if (lk_en) begin
         hit_q  <= |match;
         dest_q <= sel_dest;
      end
   end
endmodule

// File: rtl/srt_detour.sv
module srt_detour
   import spike_router_pkg::*;
(
   input  logic [NUM_LINKS-1:0]   victim,
   input  logic [NUM_LINKS-1:0]   busy,
   input  logic [NUM_LINKS-1:0]   failed,
   output logic [NUM_LINKS-1:0]   rm,
   output logic [NUM_LINKS-1:0]   add,
   output logic [2*NUM_LINKS-1:0] add_code
);
   logic [NUM_LINKS-1:0] used;

   // first-fit: try the clockwise neighbour, then the anticlockwise one
   always_comb begin
      used     = busy;
      rm       = '0;
      add      = '0;
      add_code = '0;
      for (int d = 0; d < NUM_LINKS; d++) begin
         logic [2:0] cw, ccw;
         cw  = link_add(3'(d), 1);
         ccw = link_add(3'(d), 5);
         if (victim[d]) begin
            if (!used[cw] && !failed[cw]) begin
               rm[d]                  = 1'b1;
               add[cw]                = 1'b1;
               used[cw]               = 1'b1;
               add_code[2*cw +: 2]    = ER_CW;
            end else if (!used[ccw] && !failed[ccw]) begin
               rm[d]                  = 1'b1;
               add[ccw]               = 1'b1;
               used[ccw]              = 1'b1;
               add_code[2*ccw +: 2]   = ER_CCW;
            end
         end
      end
   end
endmodule

// File: rtl/srt_drop_ctr.sv
module srt_drop_ctr #(
   parameter int W = 8
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] count
);
   localparam logic [W-1:0] TOP = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     count <= '0;
      else if (inc && count != TOP)   count <= count + 1'b1;
   end

   assert_drop_sat_R12: assert property (@(posedge clk) disable iff (!rst_n)
      count == TOP |=> count == TOP);
   assert_drop_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !inc |=> $stable(count));
endmodule

// File: rtl/spike_router.sv
module spike_router
   import spike_router_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter int DEPTH     = 16,
   parameter int TMO_W     = 12,
   parameter int DROP_W    = 8,
   localparam int NUM_OUT  = NUM_LINKS + NUM_CORES,
   localparam int SRC_W    = $clog2(NUM_OUT),
   localparam int AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   output logic                   in_ready,
   input  logic [SRC_W-1:0]       in_src,
   input  logic [HDR_W-1:0]       in_hdr,
   input  logic [KEY_W-1:0]       in_key,
   input  logic [KEY_W-1:0]       in_payload,
   input  logic                   tbl_we,
   input  logic [AW-1:0]          tbl_addr,
   input  logic                   tbl_en,
   input  logic [KEY_W-1:0]       tbl_key,
   input  logic [KEY_W-1:0]       tbl_mask,
   input  logic [NUM_OUT-1:0]     tbl_dest,
   input  logic [TMO_W-1:0]       cfg_timeout,
   input  logic [TMO_W-1:0]       cfg_detour_wait,
   input  logic [NUM_LINKS-1:0]   link_failed,
   output logic [NUM_OUT-1:0]     out_valid,
   input  logic [NUM_OUT-1:0]     out_ready,
   output logic [NUM_OUT*HDR_W-1:0] out_hdr,
   output logic [KEY_W-1:0]       out_key,
   output logic [KEY_W-1:0]       out_payload,
   output logic [DROP_W-1:0]      drop_count
);
   // elaboration-time parameter checks
   if (NUM_CORES < 1 || NUM_CORES > 18) begin : g_bad_cores
      $error("NUM_CORES must lie in 1..18");
   end
   if (DEPTH < 1 || DEPTH > 1024) begin : g_bad_depth
      $error("DEPTH must lie in 1..1024");
   end
   if (TMO_W < 2 || TMO_W > 32) begin : g_bad_tmo
      $error("TMO_W must lie in 2..32");
   end
   if (DROP_W < 1 || DROP_W > 32) begin : g_bad_drop
      $error("DROP_W must lie in 1..32");
   end

   state_e                 state_q;
   logic [SRC_W-1:0]       src_q;
   logic [HDR_W-1:0]       hdr_q;
   logic [KEY_W-1:0]       key_q, pl_q;
   logic [NUM_OUT-1:0]     pend_q;
   logic [NUM_LINKS-1:0]   used_q, det_q;
   logic [1:0]             code_q [NUM_LINKS];
   logic [TMO_W-1:0]       wait_q;

   logic                   hit_q;
   logic [NUM_OUT-1:0]     tdest_q;

   srt_table #(.DEPTH(DEPTH), .NUM_OUT(NUM_OUT)) u_tbl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (tbl_we),
      .wr_addr  (tbl_addr),
      .wr_valid (tbl_en),
      .wr_key   (tbl_key),
      .wr_mask  (tbl_mask),
      .wr_dest  (tbl_dest),
      .lk_en    (state_q == ST_LOOK),
      .lk_key   (key_q),
      .hit_q    (hit_q),
      .dest_q   (tdest_q)
   );

   // ---------------- dispatch decision ----------------
   logic               from_link, turned, disp_drop;
   logic [2:0]         src_lnk;
   er_code_e           er_in;
   logic [NUM_OUT-1:0] disp_dest;

   assign from_link = src_q < SRC_W'(NUM_LINKS);
   assign src_lnk   = src_q[2:0];
   assign er_in     = er_code_e'(hdr_q[ER_LO +: 2]);

   always_comb begin
      turned    = 1'b0;
      disp_drop = 1'b0;
      disp_dest = '0;
      if (from_link && (er_in == ER_CW || er_in == ER_CCW)) begin
         turned = 1'b1;
         disp_dest[link_add(src_lnk, (er_in == ER_CW) ? 1 : 5)] = 1'b1;
      end else if (hit_q) begin
         disp_dest = tdest_q;
      end else if (from_link) begin
         disp_dest[link_add(src_lnk, 3)] = 1'b1;
      end else begin
         disp_drop = 1'b1;
      end
   end

   // ---------------- offer window ----------------
   logic [NUM_OUT-1:0] acc, pend_n;
   logic               last_cycle;

   assign acc        = pend_q & out_ready;
   assign pend_n     = pend_q & ~acc;
   assign last_cycle = ((TMO_W+1)'(wait_q) + (TMO_W+1)'(1)) == (TMO_W+1)'(cfg_timeout);

   // ---------------- detour selection (shared by both instants) ----------------
   logic [NUM_LINKS-1:0]   dt_victim, dt_busy, dt_rm, dt_add;
   logic [2*NUM_LINKS-1:0] dt_code;
   logic [NUM_OUT-1:0]     rm_x, add_x, disp_next;

   always_comb begin
      if (state_q == ST_DISP) begin
         dt_victim = disp_dest[NUM_LINKS-1:0] & link_failed & {NUM_LINKS{~turned}};
         dt_busy   = disp_dest[NUM_LINKS-1:0];
      end else begin
         dt_victim = pend_n[NUM_LINKS-1:0] & ~det_q & {NUM_LINKS{wait_q == cfg_detour_wait}};
         dt_busy   = used_q;
      end
   end

   srt_detour u_det (
      .victim   (dt_victim),
      .busy     (dt_busy),
      .failed   (link_failed),
      .rm       (dt_rm),
      .add      (dt_add),
      .add_code (dt_code)
   );

   assign rm_x      = {{NUM_CORES{1'b0}}, dt_rm};
   assign add_x     = {{NUM_CORES{1'b0}}, dt_add};
   assign disp_next = (disp_dest & ~rm_x) | add_x;

   logic drop_inc;
   assign drop_inc = (state_q == ST_DISP && disp_drop) ||
                     (state_q == ST_SEND && pend_n != '0 && last_cycle);

   srt_drop_ctr #(.W(DROP_W)) u_drop (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (drop_inc),
      .count (drop_count)
   );

   // ---------------- state ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         src_q   <= '0;
         hdr_q   <= '0;
         key_q   <= '0;
         pl_q    <= '0;
         pend_q  <= '0;
         used_q  <= '0;
         det_q   <= '0;
         wait_q  <= '0;
         for (int i = 0; i < NUM_LINKS; i++) code_q[i] <= ER_NONE;
      end else begin
         case (state_q)
            ST_IDLE: if (in_valid) begin
               src_q   <= in_src;
               hdr_q   <= in_hdr;
               key_q   <= in_key;
               pl_q    <= in_hdr[PL_BIT] ? in_payload : '0;
               state_q <= ST_LOOK;
            end
            ST_LOOK: state_q <= ST_DISP;
            ST_DISP: begin
               wait_q <= '0;
               used_q <= disp_dest[NUM_LINKS-1:0] | dt_add;
               det_q  <= dt_add | (turned ? disp_dest[NUM_LINKS-1:0] : '0);
               for (int i = 0; i < NUM_LINKS; i++)
                  code_q[i] <= dt_add[i] ? dt_code[2*i +: 2] : ER_NONE;
               if (disp_drop || disp_next == '0) begin
                  pend_q  <= '0;
                  state_q <= ST_IDLE;
               end else begin
                  pend_q  <= disp_next;
                  state_q <= ST_SEND;
               end
            end
            ST_SEND: begin
               if (pend_n == '0 || last_cycle) begin
                  pend_q  <= '0;
                  state_q <= ST_IDLE;
               end else begin
                  wait_q <= wait_q + 1'b1;
                  pend_q <= (pend_n & ~rm_x) | add_x;
                  used_q <= used_q | dt_add;
                  det_q  <= det_q | dt_add;
                  for (int i = 0; i < NUM_LINKS; i++)
                     if (dt_add[i]) code_q[i] <= dt_code[2*i +: 2];
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign in_ready    = (state_q == ST_IDLE);
   assign out_valid   = pend_q;
   assign out_key     = key_q;
   assign out_payload = pl_q;

   for (genvar g = 0; g < NUM_OUT; g++) begin : g_hdr
      if (g < NUM_LINKS) begin : g_lnk
         assign out_hdr[g*HDR_W +: HDR_W] = {hdr_q[7:3], code_q[g], hdr_q[0]};
      end else begin : g_core
         assign out_hdr[g*HDR_W +: HDR_W] = {hdr_q[7:3], 2'b00, hdr_q[0]};
      end
   end

   // ---------------- assertions ----------------
   assert_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid != '0 |-> !in_ready);
   assert_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> !in_ready && out_valid == '0);
   assert_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid != '0 |-> (TMO_W+1)'(wait_q) < (TMO_W+1)'(cfg_timeout));
   assert_payload_R1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid != '0 && !out_hdr[PL_BIT] |-> out_payload == '0);
   assert_single_turn_R11: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && in_src < SRC_W'(NUM_LINKS) && in_hdr[2:1] == 2'b01
      |=> ##2 $onehot0(out_valid));
endmodule

// File: tb/spike_router_test.sv
module spike_router_test;
   localparam int NC = 4, NOUT = 10, DEPTH = 16, TMO_W = 12, DROP_W = 8;

   logic              clk = 1'b0, rst_n = 1'b0;
   logic              in_valid = 1'b0, in_ready;
   logic [3:0]        in_src = '0;
   logic [7:0]        in_hdr = '0;
   logic [31:0]       in_key = '0, in_payload = '0;
   logic              tbl_we = 1'b0, tbl_en = 1'b0;
   logic [3:0]        tbl_addr = '0;
   logic [31:0]       tbl_key = '0, tbl_mask = '0;
   logic [NOUT-1:0]   tbl_dest = '0;
   logic [TMO_W-1:0]  cfg_timeout = 12'd40, cfg_detour_wait = 12'd30;
   logic [5:0]        link_failed = '0;
   logic [NOUT-1:0]   out_valid, out_ready = '1;
   logic [NOUT*8-1:0] out_hdr;
   logic [31:0]       out_key, out_payload;
   logic [DROP_W-1:0] drop_count;

   int n_chk = 0, n_fail = 0;

   always #2 clk = ~clk;

   spike_router #(.NUM_CORES(NC), .DEPTH(DEPTH), .TMO_W(TMO_W), .DROP_W(DROP_W)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_src(in_src),
      .in_hdr(in_hdr), .in_key(in_key), .in_payload(in_payload), .tbl_we(tbl_we),
      .tbl_addr(tbl_addr), .tbl_en(tbl_en), .tbl_key(tbl_key), .tbl_mask(tbl_mask),
      .tbl_dest(tbl_dest), .cfg_timeout(cfg_timeout), .cfg_detour_wait(cfg_detour_wait),
      .link_failed(link_failed), .out_valid(out_valid), .out_ready(out_ready),
      .out_hdr(out_hdr), .out_key(out_key), .out_payload(out_payload), .drop_count(drop_count)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic twr(input int a, input logic en, input logic [31:0] k, m, input logic [NOUT-1:0] d);
      @(negedge clk);
      tbl_we = 1'b1; tbl_addr = 4'(a); tbl_en = en; tbl_key = k; tbl_mask = m; tbl_dest = d;
      @(negedge clk);
      tbl_we = 1'b0;
   endtask

   task automatic send(input int src, input logic [7:0] h, input logic [31:0] k, p);
      @(negedge clk);
      in_valid = 1'b1; in_src = 4'(src); in_hdr = h; in_key = k; in_payload = p;
      @(posedge clk);
      #1 in_valid = 1'b0;
   endtask

   task automatic wait_out(output int lat);
      lat = 0;
      for (int n = 1; n <= 12; n++) begin
         @(negedge clk);
         if (out_valid != '0) begin lat = n; break; end
      end
   endtask

   function automatic logic [7:0] hdr_of(input int k);
      return out_hdr[8*k +: 8];
   endfunction

   task automatic t_reset;
      chk("R13 in_ready", 64'(in_ready), 64'd1);
      chk("R13 out_valid", 64'(out_valid), 64'd0);
      chk("R13 drop_count", 64'(drop_count), 64'd0);
   endtask

   task automatic t_disabled_R13;
      int lat;
      send(1, 8'h00, 32'h0000_1234, 32'h0);   // empty table: miss from link 1
      wait_out(lat);
      chk("R13 empty table -> link 4", 64'(out_valid), 64'h010);
   endtask

   task automatic t_hit_and_latency;
      int lat;
      send(6, 8'h00, 32'h0000_12AB, 32'h0);
      wait_out(lat);
      chk("R5 latency", 64'(lat), 64'd3);
      chk("R4 multicast vector", 64'(out_valid), 64'h052);
      chk("R2 key", 64'(out_key), 64'h0000_12AB);
      send(6, 8'h00, 32'h0000_56AA, 32'h0);
      wait_out(lat);
      chk("R2 second entry", 64'(out_valid), 64'h080);
   endtask

   task automatic t_priority_R3;
      int lat;
      send(8, 8'h00, 32'h0000_1234, 32'h0);
      wait_out(lat);
      chk("R3 lowest index wins", 64'(out_valid), 64'h052);
   endtask

   task automatic t_payload_R1;
      int lat;
      send(6, 8'hC1, 32'h0000_1201, 32'hCAFE_F00D);
      wait_out(lat);
      chk("R1 long payload", 64'(out_payload), 64'hCAFE_F00D);
      chk("R1 long header", 64'(hdr_of(6)), 64'hC1);
      send(6, 8'hA0, 32'h0000_1202, 32'h1111_2222);
      wait_out(lat);
      chk("R1 short payload zero", 64'(out_payload), 64'h0);
      chk("R1 short header", 64'(hdr_of(1)), 64'hA0);
   endtask

   task automatic t_miss_R6_R7;
      int lat;
      logic [DROP_W-1:0] d0;
      send(2, 8'h00, 32'hDEAD_0000, 32'h0);
      wait_out(lat);
      chk("R6 opposite link", 64'(out_valid), 64'h020);
      d0 = drop_count;
      send(7, 8'h00, 32'hDEAD_0000, 32'h0);
      wait_out(lat);
      chk("R7 core miss no output", 64'(lat), 64'd0);
      chk("R7 drop counted", 64'(drop_count), 64'(d0 + 1'b1));
   endtask

   task automatic t_wait_R4;
      int lat;
      out_ready = '1; out_ready[4] = 1'b0;
      send(6, 8'h00, 32'h0000_1200, 32'h0);
      wait_out(lat);
      chk("R4 all copies offered", 64'(out_valid), 64'h052);
      @(negedge clk);
      chk("R4 blocked copy held", 64'(out_valid), 64'h010);
      chk("R4 input held off", 64'(in_ready), 64'd0);
      out_ready[4] = 1'b1;
      @(negedge clk);
      chk("R4 complete", 64'(out_valid), 64'h0);
      chk("R4 idle again", 64'(in_ready), 64'd1);
   endtask

   task automatic t_timeout_R8;
      int lat, cnt;
      logic [DROP_W-1:0] d0;
      d0 = drop_count;
      cfg_timeout = 12'd8; out_ready = '0;
      send(6, 8'h00, 32'h0000_1200, 32'h0);
      wait_out(lat);
      cnt = 0;
      while (out_valid != '0 && cnt < 50) begin cnt++; @(negedge clk); end
      chk("R8 offer window", 64'(cnt), 64'd8);
      chk("R8 drop counted", 64'(drop_count), 64'(d0 + 1'b1));
      chk("R8 idle", 64'(in_ready), 64'd1);
      out_ready = '1; cfg_timeout = 12'd40;
   endtask

   task automatic t_failed_R9;
      int lat;
      link_failed = 6'b000001;
      send(6, 8'h00, 32'h0000_7000, 32'h0);
      wait_out(lat);
      chk("R9 clockwise detour", 64'(out_valid), 64'h002);
      chk("R9 code 01", 64'(hdr_of(1)), 64'h02);
      send(6, 8'h00, 32'h0000_7100, 32'h0);
      wait_out(lat);
      chk("R9 anticlockwise detour", 64'(out_valid), 64'h022);
      chk("R9 code 10", 64'(hdr_of(5)), 64'h04);
      chk("R9 direct copy plain", 64'(hdr_of(1)), 64'h00);
      link_failed = '0;
   endtask

   task automatic t_blocked_R10;
      int lat, cnt;
      cfg_timeout = 12'd20; cfg_detour_wait = 12'd3;
      out_ready = '1; out_ready[0] = 1'b0;
      send(6, 8'h00, 32'h0000_7000, 32'h0);
      wait_out(lat);
      cnt = 0;
      while (out_valid == 10'h001 && cnt < 50) begin cnt++; @(negedge clk); end
      chk("R10 cycles before detour", 64'(cnt), 64'd4);
      chk("R10 moved to link 1", 64'(out_valid), 64'h002);
      chk("R10 code 01", 64'(hdr_of(1)), 64'h02);
      @(negedge clk);
      chk("R10 detour accepted", 64'(out_valid), 64'h0);
      out_ready = '1; cfg_timeout = 12'd40; cfg_detour_wait = 12'd30;
   endtask

   task automatic t_turn_R11;
      int lat;
      send(3, 8'h02, 32'h0000_1234, 32'h0);
      wait_out(lat);
      chk("R11 code 01 turn", 64'(out_valid), 64'h010);
      chk("R11 code cleared", 64'(hdr_of(4)), 64'h00);
      send(3, 8'h04, 32'h0000_1234, 32'h0);
      wait_out(lat);
      chk("R11 code 10 turn", 64'(out_valid), 64'h004);
      chk("R11 code cleared 2", 64'(hdr_of(2)), 64'h00);
   endtask

   task automatic t_sat_R12;
      for (int i = 0; i < 260; i++) begin
         send(9, 8'h00, 32'hBEEF_0000, 32'h0);
         repeat (3) @(negedge clk);
      end
      chk("R12 saturated", 64'(drop_count), 64'hFF);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_disabled_R13;
      twr(0, 1'b0, 32'h0000_1234, 32'hFFFF_FFFF, 10'h200);  // disabled entry
      twr(2, 1'b1, 32'h0000_1200, 32'hFFFF_FF00, 10'h052);
      twr(5, 1'b1, 32'h0000_1234, 32'hFFFF_FFFF, 10'h100);
      twr(9, 1'b1, 32'h0000_5600, 32'hFFFF_FF00, 10'h080);
      twr(6, 1'b1, 32'h0000_7000, 32'hFFFF_FFFF, 10'h001);
      twr(7, 1'b1, 32'h0000_7100, 32'hFFFF_FFFF, 10'h003);
      t_hit_and_latency;
      t_priority_R3;
      t_payload_R1;
      t_miss_R6_R7;
      t_wait_R4;
      t_timeout_R8;
      t_failed_R9;
      t_blocked_R10;
      t_turn_R11;
      t_sat_R12;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule